// File: doc/BRIEF.md
# Infrared Carrier and Envelope Transmitter

This block drives an infrared emitter. A carrier generator runs on the system clock and shapes a waveform from three settings: one high time and two low times that take turns. Each low time is its own setting, and when the two differ by one clock the average carrier period falls between two whole clock counts.

The carrier is gated by an envelope. Software fills a 32-byte transmit store and then pulses `start`. The block walks the entries in order, and they alternate: high (carrier on), low (output held at 0), high, and so on. A prescaler turns the system clock into a base tick, and each entry is a duration measured in those ticks.

The entries can be coded in two ways:
- **Byte mode:** each byte is a count of base units. The high unit and the low unit are two separate settings.
- **Word mode:** a pair of bytes forms one 16-bit tick count.

A zero-length entry ends the frame. `busy` covers the whole frame, and a one-cycle `done` pulse closes it.

Top module: `irtx_top`

## Requirements
- R1: After reset, `busy`, `done` and `ir_out` are 0.
- R2: Within a high segment the carrier repeats this cycle: high for `car_high` clocks, low for `car_low_a`, high for `car_high`, low for `car_low_b`. A setting of 0 behaves as 1.
- R3: The carrier phase restarts at the first clock of every high segment, so `ir_out` is 1 in that clock.
- R4: `ir_out` is 0 throughout every low segment and whenever `busy` is 0.
- R5: The base tick comes once every `tick_div`+1 system clocks, and its count restarts at the start of each segment.
- R6: In byte mode (`word_mode`=0), entry i is the byte at address i. Even entries are high and odd entries are low. The entry lasts byte × (`unit_high` for even i, `unit_low` for odd i) × (`tick_div`+1) clocks.
- R7: In word mode (`word_mode`=1), entry k takes its upper byte from address 2k and its lower byte from address 2k+1. It lasts word × (`tick_div`+1) clocks, and even k is high.
- R8: An entry whose duration is zero ends the frame. If no such entry exists, the frame ends after the last entry: 32 entries in byte mode, 16 in word mode.
- R9: `busy` rises one clock after `start` is sampled while idle and falls when the last entry completes. In that same clock `done` is 1 for exactly one cycle. A frame whose first entry is zero gives only the `done` pulse.
- R10: `start` has no effect while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| car_high | input | 8 | Carrier high time in clocks |
| car_low_a | input | 8 | First carrier low time in clocks |
| car_low_b | input | 8 | Second carrier low time in clocks |
| tick_div | input | 8 | Prescaler setting; the tick period is this value plus 1 clocks |
| unit_high | input | 8 | Byte mode: ticks per count in high entries |
| unit_low | input | 8 | Byte mode: ticks per count in low entries |
| word_mode | input | 1 | 0 = byte entries, 1 = 16-bit entries |
| wr_en | input | 1 | Transmit store write strobe |
| wr_addr | input | 5 | Transmit store byte address |
| wr_data | input | 8 | Transmit store write data |
| start | input | 1 | Begin a frame (ignored while busy) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| ir_out | output | 1 | Infrared drive output |

## Verification
When `start` is sampled at an edge, the first segment is already active in the clock that follows. From then on, each segment's output in its j-th clock depends only on the carrier settings and on j.

`busy` falls, and `done` pulses, exactly the summed segment lengths in clocks after that first clock. The bench builds the segment list from its own copy of the store and turns it into an expected value for `busy`, `done` and `ir_out` in every clock up to one past the frame end. It samples on the falling edge, half a period after the edge that moved the registers.

The sweeps cover carrier settings from 0 to 2, and unit and prescaler settings that include zero-length terminations.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
    localparam int CW        = 8;             // width of every timing setting
    localparam int BUF_BYTES = 32;            // transmit store depth
    localparam int AW        = $clog2(BUF_BYTES);
    localparam int IW        = AW + 1;        // entry index incl. one-past-end
    localparam int DW        = 2 * CW;        // segment duration in ticks

    typedef enum logic [1:0] {PH_HI_A, PH_LO_A, PH_HI_B, PH_LO_B} car_phase_e;

    typedef struct packed {
        logic          valid;   // index inside the store
        logic          level;   // 1 = carrier on
        logic [DW-1:0] dur;     // duration in base ticks
    } seg_t;

    function automatic logic [CW-1:0] at_least_one(input logic [CW-1:0] v);
        return (v == '0) ? CW'(1) : v;
    endfunction
endpackage

// File: rtl/irtx_prescaler.sv
module irtx_prescaler
    import irtx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic [CW-1:0] div,
    output logic          tick
);
    logic [CW-1:0] cnt;

    assign tick = (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || clear || tick) cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end

    // R5
    tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0));
endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier
    import irtx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] t_high,
    input  logic [CW-1:0] t_low_a,
    input  logic [CW-1:0] t_low_b,
    output logic          car
);
    car_phase_e    ph;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_comb begin
        unique case (ph)
            PH_LO_A: lim = at_least_one(t_low_a);
            PH_LO_B: lim = at_least_one(t_low_b);
            default: lim = at_least_one(t_high);
        endcase
    end

    assign car = (ph == PH_HI_A) || (ph == PH_HI_B);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph  <= PH_HI_A;
            cnt <= '0;
        end else if (cnt == lim - 1'b1) begin
            cnt <= '0;
            unique case (ph)
                PH_HI_A: ph <= PH_LO_A;
                PH_LO_A: ph <= PH_HI_B;
                PH_HI_B: ph <= PH_LO_B;
                default: ph <= PH_HI_A;
            endcase
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && (ph != $past(ph))) |-> (cnt == '0));
endmodule

// File: rtl/irtx_seq.sv
module irtx_seq
    import irtx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          word_mode,
    input  logic [CW-1:0] unit_high,
    input  logic [CW-1:0] unit_low,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          start,
    input  logic          tick,
    output logic          advance,
    output logic          busy,
    output logic          done,
    output logic          env
);
    logic [CW-1:0] store [BUF_BYTES];
    logic [IW-1:0] idx;
    logic [IW-1:0] target;
    logic [DW-1:0] rem;
    seg_t          nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BUF_BYTES; i++) store[i] <= '0;
        end else if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    assign target  = busy ? idx + 1'b1 : '0;
    assign advance = (!busy && start) || (busy && tick && rem == DW'(1));

    always_comb begin
        nxt.level = ~target[0];
        if (word_mode) begin
            nxt.valid = (target < IW'(BUF_BYTES / 2));
            nxt.dur   = {store[{target[AW-2:0], 1'b0}], store[{target[AW-2:0], 1'b1}]};
        end else begin
            nxt.valid = (target < IW'(BUF_BYTES));
            nxt.dur   = store[target[AW-1:0]] * (target[0] ? unit_low : unit_high);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            env  <= 1'b0;
            idx  <= '0;
            rem  <= '0;
        end else begin
            done <= 1'b0;
            if (advance) begin
                if (nxt.valid && nxt.dur != '0) begin
                    busy <= 1'b1;
                    idx  <= target;
                    rem  <= nxt.dur;
                    env  <= nxt.level;
                end else begin
                    busy <= 1'b0;
                    env  <= 1'b0;
                    done <= 1'b1;
                end
            end else if (busy && tick) begin
                rem <= rem - 1'b1;
            end
        end
    end

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R9
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !(tick && rem == DW'(1))) |=> (busy && $stable(idx)));
endmodule

// File: rtl/irtx_top.sv
module irtx_top
    import irtx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] car_high,
    input  logic [7:0] car_low_a,
    input  logic [7:0] car_low_b,
    input  logic [7:0] tick_div,
    input  logic [7:0] unit_high,
    input  logic [7:0] unit_low,
    input  logic       word_mode,
    input  logic       wr_en,
    input  logic [4:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       start,
    output logic       busy,
    output logic       done,
    output logic       ir_out
);
    logic tick;
    logic advance;
    logic env;
    logic car;

    irtx_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .word_mode (word_mode),
        .unit_high (unit_high),
        .unit_low  (unit_low),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .start     (start),
        .tick      (tick),
        .advance   (advance),
        .busy      (busy),
        .done      (done),
        .env       (env)
    );

    irtx_prescaler u_presc (
        .clk   (clk),
        .rst   (rst),
        .clear (advance || !busy),
        .div   (tick_div),
        .tick  (tick)
    );

    irtx_carrier u_car (
        .clk     (clk),
        .rst     (rst),
        .run     (env),
        .t_high  (car_high),
        .t_low_a (car_low_a),
        .t_low_b (car_low_b),
        .car     (car)
    );

    assign ir_out = env & car;

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ir_out);
    // R3
    carrier_restart_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(env) |-> ir_out);
endmodule

// File: tb/tb_irtx_top.sv
module tb_irtx_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] car_high = 8'd1, car_low_a = 8'd1, car_low_b = 8'd1;
    logic [7:0] tick_div = 8'd0, unit_high = 8'd1, unit_low = 8'd1;
    logic word_mode = 1'b0;
    logic wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic start = 1'b0;
    logic busy, done, ir_out;

    int checks = 0;
    int errors = 0;
    int bm [32];
    int sl [32];
    bit sv [32];
    int ns;
    int total;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irtx_top dut (
        .clk(clk), .rst(rst), .car_high(car_high), .car_low_a(car_low_a),
        .car_low_b(car_low_b), .tick_div(tick_div), .unit_high(unit_high),
        .unit_low(unit_low), .word_mode(word_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .start(start),
        .busy(busy), .done(done), .ir_out(ir_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic wbyte(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d); bm[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_store();
        for (int i = 0; i < 32; i++) wbyte(i, 0);
    endtask

    // segment list from the bench's own copy of the store (R6, R7, R8)
    task automatic build();
        ns = 0; total = 0;
        if (word_mode) begin
            for (int k = 0; k < 16; k++) begin
                int w;
                w = bm[2*k] * 256 + bm[2*k+1];
                if (w == 0) break;
                sl[ns] = w * (int'(tick_div) + 1); sv[ns] = (k % 2 == 0);
                total += sl[ns]; ns++;
            end
        end else begin
            for (int i = 0; i < 32; i++) begin
                int d;
                d = bm[i] * ((i % 2) ? int'(unit_low) : int'(unit_high));
                if (d == 0) break;
                sl[ns] = d * (int'(tick_div) + 1); sv[ns] = (i % 2 == 0);
                total += sl[ns]; ns++;
            end
        end
    endtask

    function automatic int exp_ir(input int j);
        int s, h, a, b, per, m;
        s = 0;
        h = eff(car_high); a = eff(car_low_a); b = eff(car_low_b);
        per = 2*h + a + b;
        for (int k = 0; k < ns; k++) begin
            if (j < s + sl[k]) begin
                if (!sv[k]) return 0;
                m = (j - s) % per;
                return ((m < h) || (m >= h + a && m < 2*h + a)) ? 1 : 0;
            end
            s += sl[k];
        end
        return 0;
    endfunction

    task automatic run_frame(input string ir_req, input int restart_at);
        build();
        @(negedge clk);
        start = 1'b1;
        for (int j = 0; j <= total + 1; j++) begin
            @(negedge clk);
            start = 1'b0;
            check("R9 busy", int'(busy), (j < total) ? 1 : 0);
            check("R9 done", int'(done), (j == total) ? 1 : 0);
            check(ir_req, int'(ir_out), exp_ir(j));
            if (j == restart_at) start = 1'b1; // R10: ignored while busy
        end
        start = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) bm[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 ir_out", int'(ir_out), 0);

        // R6 basic byte-mode frame, R4 low segments quiet
        car_high = 2; car_low_a = 3; car_low_b = 4;
        wbyte(0, 5); wbyte(1, 3); wbyte(2, 7); wbyte(3, 2);
        run_frame("R6", -1);

        // R10 start pulsed mid-frame
        run_frame("R10", 6);

        // R5 prescaler and separate units
        tick_div = 2; unit_high = 3; unit_low = 2;
        car_high = 1; car_low_a = 1; car_low_b = 2;
        run_frame("R5", -1);

        // R7 word mode: 0x000A, 0x0005, 0x0102 (upper byte at even address)
        clear_store();
        word_mode = 1; tick_div = 1;
        wbyte(0, 8'h00); wbyte(1, 8'h0A); wbyte(2, 8'h00); wbyte(3, 8'h05);
        wbyte(4, 8'h01); wbyte(5, 8'h02);
        run_frame("R7", -1);

        // R8 word mode with no terminator: 16 entries
        for (int k = 0; k < 16; k++) begin wbyte(2*k, 0); wbyte(2*k+1, 3); end
        tick_div = 0;
        run_frame("R8", -1);

        // R8 byte mode with no terminator: 32 entries
        word_mode = 0; unit_high = 1; unit_low = 1;
        for (int i = 0; i < 32; i++) wbyte(i, (i % 3) + 1);
        run_frame("R8", -1);

        // R8 zero first entry: done only
        wbyte(0, 0);
        run_frame("R8", -1);

        // R2 R3 carrier sweep incl. zero settings; two high segments around a short low
        clear_store();
        wbyte(0, 1); wbyte(1, 1); wbyte(2, 1);
        unit_high = 40; unit_low = 1; tick_div = 0;
        for (int h = 0; h < 3; h++)
            for (int a = 0; a < 3; a++)
                for (int b = 0; b < 3; b++) begin
                    car_high = 8'(h); car_low_a = 8'(a); car_low_b = 8'(b);
                    run_frame("R2", -1);
                    run_frame("R3", -1);
                end

        // R6 R5 R8 unit and prescaler sweep, zero units end the frame
        clear_store();
        wbyte(0, 2); wbyte(1, 3); wbyte(2, 1);
        car_high = 1; car_low_a = 2; car_low_b = 1;
        for (int uh = 0; uh < 4; uh++)
            for (int ul = 0; ul < 4; ul++)
                for (int p = 0; p < 3; p++) begin
                    unit_high = 8'(uh); unit_low = 8'(ul); tick_div = 8'(p);
                    run_frame("R6", -1);
                end

        // R4 idle output after all frames
        @(negedge clk);
        check("R4 idle ir_out", int'(ir_out), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule